// File: doc/BRIEF.md
# Serial Funnel Shifter

This block performs a double-operand shift: a destination word is shifted by a given number of positions, and the vacated positions are refilled with bits taken from a second word, the source. It moves one bit per clock. It is meant to sit beside an execution unit that issues the occasional double shift and can tolerate a multi-cycle latency in exchange for a very small datapath.

The caller presents a direction, an operand size (16 or 32 bits), both operands and a 5-bit count, and pulses a start strobe. The block raises busy, makes one transfer per cycle, and then pulses done. At that point the final destination value and the last bit pushed out of the destination (the carry) are on its outputs. The source operand is only read; the caller's copy is never written. The outputs hold their value until the next accepted start.

Top module: `serial_funnel_shifter`

## Requirements
- R1: With `dir_i`=0 (left), each transfer moves the destination one place toward its top bit. The bit entering position 0 is the next source bit, taken from the most significant bit of the active width downward. After n transfers in 32-bit mode the result is the upper word of `{dst, src} << n`.
- R2: With `dir_i`=1 (right), each transfer moves the destination one place toward bit 0. The bit entering the top position of the active width is the next source bit, taken from bit 0 upward. After n transfers the result is the lower word of `{src, dst} >> n`.
- R3: The count is a 5-bit value from 0 to 31. Exactly that many transfers are performed, and every count in that range gives the funnel result of R1 or R2.
- R4: A count of 0 keeps busy high for a single cycle, then pulses done. The result equals the loaded destination and the carry keeps its previous value.
- R5: On each transfer the carry takes the bit that leaves the destination: the top bit of the active width for a left shift, or bit 0 for a right shift. The carry does not change in any cycle without a transfer.
- R6: `size_i`=0 selects 16-bit operation on the low halves of both operands. The upper operand bits are ignored and the upper 16 result bits read 0. Once the 16 source bits are used up, zeros enter the destination.
- R7: Busy goes high in the cycle after an accepted start and stays high for max(n,1) cycles. A start raised while busy is ignored.
- R8: Done is high for exactly one cycle, the one that follows the last transfer, and busy is low in that cycle. While idle and without a start, the result does not change.
- R9: After reset the result, carry, busy and done all read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, accepted only while idle |
| dir_i | input | 1 | 0 = shift left, 1 = shift right |
| size_i | input | 1 | 0 = 16-bit operands, 1 = 32-bit operands |
| dst_i | input | DATA_W | Destination operand |
| src_i | input | DATA_W | Source operand supplying the fill bits |
| count_i | input | CNT_W | Number of bit transfers (0 to 31) |
| res_o | output | DATA_W | Shifted destination |
| carry_o | output | 1 | Last bit shifted out of the destination |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The shift-step properties assume that direction and size are captured only when a start is accepted. They are written only for the moments when the control says a transfer occurs, so they say nothing about the value of `dir_i` or `size_i` while busy. The stimulus drives the operand inputs and strobe on the falling edge and holds them steady across the following rising edge. It also deliberately raises start in the middle of an operation, with different operands, so that the ignore rule is exercised against the reference model. Counts cover 0, 1, 16, beyond 16 in half mode, and 31, plus a batch of random operations in both sizes and directions.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic {
    SFS_LEFT  = 1'b0,
    SFS_RIGHT = 1'b1
  } sfs_dir_e;

  typedef enum logic {
    SFS_HALF = 1'b0,
    SFS_FULL = 1'b1
  } sfs_size_e;
endpackage

// File: rtl/sfs_rst_sync.sv
module sfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_no = chain_q[STAGES-1];
endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             load_o,
  output logic             step_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] left_q, left_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             finish;
  logic             left_en;

  always_comb begin
    load_o  = start_i && !busy_q;
    step_o  = busy_q && (left_q != '0);
    finish  = busy_q && (left_q <= CNT_W'(1));
    left_en = load_o || step_o;
    left_d  = left_q;
    if (load_o)      left_d = cnt_i;
    else if (step_o) left_d = left_q - CNT_W'(1);
    busy_d = busy_q;
    if (load_o)      busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;
    done_d = finish;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (left_en) left_q <= left_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/sfs_datapath.sv
module sfs_datapath
  import sfs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              dir_i,
  input  logic              size_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              op_full_o,
  output logic              op_left_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] dst_q, dst_d, src_q, src_d;
  logic              carry_q, carry_d;
  sfs_dir_e          dir_q, dir_d;
  sfs_size_e         size_q, size_d;

  logic [DATA_W-1:0] load_mask;
  logic [DATA_W-1:0] dst_step, src_step, lane_on;
  logic              size_full, dir_left;
  logic              src_top, dst_top;
  logic              reg_en;

  assign size_full = (size_q == SFS_FULL);
  assign dir_left  = (dir_q == SFS_LEFT);
  assign src_top   = size_full ? src_q[DATA_W-1] : src_q[HALF_W-1];
  assign dst_top   = size_full ? dst_q[DATA_W-1] : dst_q[HALF_W-1];
  assign load_mask = size_i ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic from_lo, from_hi, src_lo, src_hi;
    if (i == 0) begin : g_lsb
      assign from_lo = src_top;
      assign src_lo  = 1'b0;
    end else begin : g_up
      assign from_lo = dst_q[i-1];
      assign src_lo  = src_q[i-1];
    end
    if (i == DATA_W-1) begin : g_msb
      assign from_hi = size_full & src_q[0];
      assign src_hi  = 1'b0;
    end else if (i == HALF_W-1) begin : g_half_top
      assign from_hi = size_full ? dst_q[i+1] : src_q[0];
      assign src_hi  = size_full & src_q[i+1];
    end else begin : g_dn
      assign from_hi = dst_q[i+1];
      assign src_hi  = src_q[i+1];
    end
    assign lane_on[i]  = (i < HALF_W) || size_full;
    assign dst_step[i] = lane_on[i] & (dir_left ? from_lo : from_hi);
    assign src_step[i] = lane_on[i] & (dir_left ? src_lo : src_hi);
  end

  always_comb begin
    reg_en  = load_i || step_i;
    dst_d   = dst_q;
    src_d   = src_q;
    carry_d = carry_q;
    dir_d   = dir_q;
    size_d  = size_q;
    if (load_i) begin
      dir_d  = sfs_dir_e'(dir_i);
      size_d = sfs_size_e'(size_i);
      dst_d  = dst_i & load_mask;
      src_d  = src_i & load_mask;
    end else if (step_i) begin
      dst_d   = dst_step;
      src_d   = src_step;
      carry_d = dir_left ? dst_top : dst_q[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q   <= '0;
      src_q   <= '0;
      carry_q <= 1'b0;
      dir_q   <= SFS_LEFT;
      size_q  <= SFS_HALF;
    end else if (reg_en) begin
      dst_q   <= dst_d;
      src_q   <= src_d;
      carry_q <= carry_d;
      dir_q   <= dir_d;
      size_q  <= size_d;
    end
  end

  assign res_o     = dst_q;
  assign carry_o   = carry_q;
  assign op_full_o = size_full;
  assign op_left_o = dir_left;
endmodule

// File: rtl/serial_funnel_shifter.sv
module serial_funnel_shifter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic              size_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              busy_o,
  output logic              done_o
);
  logic rst_s_n;
  logic load, step;
  logic op_full, op_left;

  sfs_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (rst_s_n)
  );

  sfs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_s_n),
    .start_i (start_i),
    .cnt_i   (count_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  sfs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_s_n),
    .load_i    (load),
    .step_i    (step),
    .dir_i     (dir_i),
    .size_i    (size_i),
    .dst_i     (dst_i),
    .src_i     (src_i),
    .res_o     (res_o),
    .carry_o   (carry_o),
    .op_full_o (op_full),
    .op_left_o (op_left)
  );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              step,
  input logic              full,
  input logic              left,
  input logic [DATA_W-1:0] res,
  input logic              carry
);
  localparam int HALF_W = DATA_W / 2;

  AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step && left && full |=> res[DATA_W-1:1] == $past(res[DATA_W-2:0]));  // R1
  AST_RIGHT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step && !left && full |=> res[DATA_W-2:0] == $past(res[DATA_W-1:1]));  // R2
  AST_LEFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    step && left && full |=> carry == $past(res[DATA_W-1]));  // R5
  AST_LEFT_CARRY_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    step && left && !full |=> carry == $past(res[HALF_W-1]));  // R5
  AST_RIGHT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    step && !left |=> carry == $past(res[0]));  // R5
  AST_CARRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(carry));  // R5
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> res[DATA_W-1:HALF_W] == '0);  // R6
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);  // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(res));  // R8
endmodule

bind serial_funnel_shifter sfs_checker #(.DATA_W(DATA_W)) u_sfs_chk (
  .clk   (clk_i),
  .rst_n (rst_s_n),
  .start (start_i),
  .busy  (busy_o),
  .done  (done_o),
  .step  (step),
  .full  (op_full),
  .left  (op_left),
  .res   (res_o),
  .carry (carry_o)
);

// File: tb/serial_funnel_shifter_test.sv
module serial_funnel_shifter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, dir, size;
  logic [31:0] dst, src;
  logic [4:0]  cnt;
  logic [31:0] res;
  logic        carry, busy, done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  serial_funnel_shifter uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_i(dir), .size_i(size),
    .dst_i(dst), .src_i(src), .count_i(cnt),
    .res_o(res), .carry_o(carry), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference, one step per clock
  logic [31:0] m_res, m_mask;
  logic        m_carry, m_busy, m_done, m_right;
  int          m_rem, m_w;
  bit          m_bit;
  bit          q_src[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_res = '0; m_carry = 0; m_busy = 0; m_done = 0; m_rem = 0;
      q_src.delete();
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_rem == 0) begin
          m_busy = 0; m_done = 1;
        end else begin
          m_bit = (q_src.size() > 0) ? q_src.pop_front() : 1'b0;
          if (!m_right) begin
            m_carry = m_res[m_w-1];
            m_res = ((m_res << 1) | {31'b0, m_bit}) & m_mask;
          end else begin
            m_carry = m_res[0];
            m_res = (m_res >> 1) | ({31'b0, m_bit} << (m_w-1));
          end
          m_rem--;
          if (m_rem == 0) begin m_busy = 0; m_done = 1; end
        end
      end else if (start) begin
        m_busy = 1; m_right = dir;
        m_w = size ? 32 : 16;
        m_mask = size ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        m_res = dst & m_mask;
        m_rem = int'(cnt);
        q_src.delete();
        if (!dir) for (int k = m_w-1; k >= 0; k--) q_src.push_back(src[k]);
        else      for (int k = 0; k < m_w; k++)    q_src.push_back(src[k]);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1/R2 result vs model", res, m_res);
      chk("R5 carry vs model", 32'(carry), 32'(m_carry));
      chk("R7 busy vs model", 32'(busy), 32'(m_busy));
      chk("R8 done vs model", 32'(done), 32'(m_done));
    end
  end

  function automatic void funnel(input bit right, input bit full, input logic [31:0] d,
                                 input logic [31:0] s, input int n, input logic cin,
                                 output logic [31:0] r, output logic c);
    int w = full ? 32 : 16;
    logic [31:0] m = full ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    logic [127:0] v, t, u;
    d = d & m; s = s & m;
    if (!right) begin
      v = ({96'b0, d} << w) | {96'b0, s};
      v = v << (128 - 2*w);
      t = v << n;
      r = t[127:96] >> (32 - w);
      u = v << ((n > 0) ? n-1 : 0);
      c = (n > 0) ? u[127] : cin;
    end else begin
      v = ({96'b0, s} << w) | {96'b0, d};
      t = v >> n;
      r = t[31:0] & m;
      u = v >> ((n > 0) ? n-1 : 0);
      c = (n > 0) ? u[0] : cin;
    end
  endfunction

  task automatic run_op(input string tag, input bit right, input bit full,
                        input logic [31:0] d, input logic [31:0] s, input int n,
                        input bit disturb);
    logic [31:0] er; logic ec, cin;
    int cycles = 0, guard = 0;
    @(negedge clk);
    cin = carry;
    funnel(right, full, d, s, n, cin, er, ec);
    start = 1; dir = right; size = full; dst = d; src = s; cnt = 5'(n);
    @(negedge clk);
    start = 0;
    while (!done && guard < 100) begin
      if (busy) cycles++;
      if (disturb && cycles == 2) begin
        start = 1; dst = ~d; src = ~s; cnt = 5'd1; dir = ~right;
      end else start = 0;
      @(negedge clk);
      guard++;
    end
    start = 0;
    chk({tag, " result"}, res, er);
    chk({tag, " carry R5"}, 32'(carry), 32'(ec));
    chk({tag, " busy length R7"}, 32'(cycles), 32'((n > 0) ? n : 1));
    chk({tag, " done without busy R8"}, 32'({done, busy}), 32'h2);
    @(negedge clk);
    chk({tag, " done single R8"}, 32'(done), 32'h0);
    chk({tag, " idle hold R8"}, res, er);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; dir = 0; size = 1; dst = '0; src = '0; cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R9 reset res", res, 32'h0);
    chk("R9 reset flags", 32'({carry, busy, done}), 32'h0);

    run_op("R1 left 32 n5",  0, 1, 32'h1234_5678, 32'h9ABC_DEF0, 5, 0);
    run_op("R2 right 32 n8", 1, 1, 32'h1234_5678, 32'h9ABC_DEF0, 8, 0);
    run_op("R3 left 32 n31", 0, 1, 32'hF0F0_0F0F, 32'h8000_0001, 31, 0);
    run_op("R3 right 32 n31", 1, 1, 32'h0000_0001, 32'hFFFF_FFFE, 31, 0);
    run_op("R5 right 32 n1", 1, 1, 32'h0000_0001, 32'h0000_0000, 1, 0);
    run_op("R4 zero count", 0, 1, 32'hDEAD_BEEF, 32'h1111_1111, 0, 0);
    run_op("R6 left 16 n4",  0, 0, 32'hFFFF_1234, 32'hAAAA_C000, 4, 0);
    run_op("R6 left 16 n16", 0, 0, 32'h0000_8001, 32'h0000_5A5A, 16, 0);
    run_op("R6 right 16 n20", 1, 0, 32'h5555_F00F, 32'h7777_ABCD, 20, 0);
    run_op("R6 left 16 n31", 0, 0, 32'h0000_FFFF, 32'h0000_FFFF, 31, 0);
    run_op("R7 start ignored", 0, 1, 32'h0F0F_0F0F, 32'hC3C3_C3C3, 10, 1);
    run_op("R4 zero count half", 1, 0, 32'hABCD_1234, 32'h0, 0, 0);
    for (int k = 0; k < 40; k++)
      run_op("R1/R2 random", 1'($urandom), 1'($urandom), $urandom, $urandom,
             int'($urandom % 32), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule